// File: doc/BRIEF.md
# Prioritized Interrupt Status Controller

This block collects the events of a two-wire bus controller into sticky flags and raises one interrupt line. A bus engine, which is outside this block, pulses one-cycle event strobes. Each strobe at a valid position sets its flag, and the flag holds until software clears it. A per-event enable mask selects which flags can drive the interrupt line. A read-only bit shows whether the bus lines are busy at this moment. That bit never takes part in the interrupt.

Software has two ways to service events. In the first, it reads the status word and then writes ones to the bits it has handled. In the second, used when the legacy input is high, it reads a vector register. The vector returns the code of the highest-priority pending event and clears that one flag as a side effect of the read.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, all flags and all enable bits are 0 and `irq` is low.
- R2: An event strobe sets its flag one clock later, and the flag stays set until it is cleared. The strobe positions are: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 10 transmit underflow, 11 receive overrun, 13 receive drain, 14 transmit drain. Strobes at any other position are ignored.
- R3: A write to address 0 clears every flag whose `wdata` bit is 1. Flags whose `wdata` bit is 0 are left unchanged.
- R4: If a strobe and a clear (by write or by vector read) hit the same flag in the same cycle, the flag stays set.
- R5: `irq` is high in exactly the cycles in which some flag and its enable bit, at the same position, are both 1.
- R6: Address 1 reads and writes the enable mask. Only the event positions of R2 can be written; every other bit reads 0.
- R7: Bit 12 of a read at address 0 follows `bus_busy` in the same cycle. Writes to bit 12 have no effect, and `bus_busy` never raises `irq`.
- R8: When `legacy` is 1, a read at address 2 returns the vector code of the lowest-numbered pending event among 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready and 5 transmit ready. These events sit at bits 0 to 4. The vector ignores the enable mask, and it returns 0 if none of these events is pending.
- R9: A vector read in legacy mode clears the flag it reports, one clock later.
- R10: When `legacy` is 0, a read at address 2 returns 0 and clears nothing. A read at address 3 always returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 16 | One-cycle event strobes, one per bit position |
| bus_busy | input | 1 | Live bus-busy level |
| legacy | input | 1 | Enables the read-to-clear vector register |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the vector side effect) |
| addr | input | 2 | Register address: 0 status, 1 enable, 2 vector |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from the current state |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the cycle in which an event arrives together with a clear of the same bit. A design that lets the clear win would silently lose an event. It loads several vector-capable events at once and drains them through vector reads. A wrong priority encoder would return codes out of ascending order, and a missing side effect would return the same code again. The bench writes ones to bit 12 and to the unused positions, and it drives `bus_busy` high while every enable bit is set. A design that stores bit 12, or routes it into the interrupt, would show a stale bit or a spurious `irq`. Vector reads with `legacy` low must return 0 and leave the flags in place, so a block that ignores the mode input would drop pending status.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int W      = 16,
  parameter int NVEC   = 5,
  parameter int BUSY_B = 12,
  parameter logic [W-1:0] EVT_MASK = 16'h6C1F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         bus_busy,
  input  logic         legacy,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);
  localparam int CW = $clog2(NVEC + 1);

  logic [W-1:0]  flags, en;
  logic [CW-1:0] vec_code;
  logic [W-1:0]  vec_hot;

  always_comb begin
    vec_code = '0;
    vec_hot  = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (flags[i]) begin
        vec_code = CW'(i + 1);
        vec_hot  = W'(1) << i;
      end
    end
  end

  wire st_wr  = wr_en && addr == 2'd0;
  wire en_wr  = wr_en && addr == 2'd1;
  wire vec_rd = rd_en && legacy && addr == 2'd2;
  wire [W-1:0] clr = (st_wr ? wdata : '0) | (vec_rd ? vec_hot : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
    end else begin
      flags <= ((flags & ~clr) | evt) & EVT_MASK;
      if (en_wr) en <= wdata & EVT_MASK;
    end
  end

  assign irq = |(flags & en);

  always_comb begin
    case (addr)
      2'd0:    rdata = flags | (W'(bus_busy) << BUSY_B);
      2'd1:    rdata = en;
      2'd2:    rdata = legacy ? W'(vec_code) : '0;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int W = 16,
  parameter logic [W-1:0] EVT_MASK = 16'h6C1F
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] evt,
  input logic         legacy,
  input logic         wr_en,
  input logic         rd_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] flags,
  input logic [W-1:0] en,
  input logic         irq
);
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0]) |=> flags[0]);

  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> ((~flags & $past(flags)) == '0));

  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> ((flags & $past(wdata) & ~$past(evt)) == '0));

  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);

  a_r7_busy_unstored: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[12] && !en[12]);

  a_r9_vec_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && legacy && addr == 2'd2 && flags[0] && !evt[0]) |=> !flags[0]);

  a_r10_no_vec_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !legacy) |=> ((~flags & $past(flags)) == '0));
endmodule

bind irq_status_ctrl irq_status_chk #(.W(W), .EVT_MASK(EVT_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .legacy(legacy), .wr_en(wr_en),
  .rd_en(rd_en), .addr(addr), .wdata(wdata), .flags(flags), .en(en), .irq(irq)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MASK = 16'h6C1F;

  logic clk = 0, rst_n = 0, bus_busy = 0, legacy = 0, wr_en = 0, rd_en = 0;
  logic [15:0] evt = 0, wdata = 0, rdata;
  logic [1:0] addr = 0;
  logic irq;
  int total = 0, bad = 0;
  logic [15:0] m_flags = 0, m_en = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl dut (.clk(clk), .rst_n(rst_n), .evt(evt), .bus_busy(bus_busy),
    .legacy(legacy), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  function automatic int vcode(logic [15:0] f);
    for (int i = 0; i < 5; i++) if (f[i]) return i + 1;
    return 0;
  endfunction

  function automatic logic [15:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return m_flags | (16'(bus_busy) << 12);
      2'd1: return m_en;
      2'd2: return legacy ? 16'(vcode(m_flags)) : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [15:0] e, logic w, logic r, logic [1:0] a, logic [15:0] d,
                      string req);
    logic [15:0] clr;
    @(negedge clk);
    evt = e; wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    chk("R5 irq", 16'(irq), 16'(|(m_flags & m_en)));
    if (r) chk(req, rdata, exp_read(a));
    clr = 0;
    if (w && a == 2'd0) clr |= d;
    if (r && legacy && a == 2'd2 && vcode(m_flags) != 0) clr |= 16'd1 << (vcode(m_flags) - 1);
    if (w && a == 2'd1) m_en = d & MASK;
    m_flags = ((m_flags & ~clr) | e) & MASK;
    @(posedge clk);
    #1;
    evt = 0; wr_en = 0; rd_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset irq", 16'(irq), 16'h0);
    rst_n = 1;
    step(0, 0, 1, 2'd0, 0, "R1 reset status");
    step(0, 0, 1, 2'd1, 0, "R1 reset enable");

    // R2: all positions strobed, only event bits stored
    step(16'hFFFF, 0, 0, 2'd0, 0, "");
    step(0, 0, 1, 2'd0, 0, "R2 sticky set");
    // R3: clear some, keep others
    step(0, 1, 0, 2'd0, 16'h0C05, "");
    step(0, 0, 1, 2'd0, 0, "R3 w1c");
    // R4: event and clear on same bit
    step(16'h0002, 1, 0, 2'd0, 16'h0002, "");
    step(0, 0, 1, 2'd0, 0, "R4 event wins");
    // R6/R7: write busy bit and unused bits
    step(0, 1, 0, 2'd1, 16'hFFFF, "");
    step(0, 0, 1, 2'd1, 0, "R6 enable mask");
    step(0, 1, 0, 2'd0, 16'hFFFF, "");
    bus_busy = 1;
    step(0, 0, 1, 2'd0, 0, "R7 busy live, no irq");
    bus_busy = 0;
    step(0, 0, 1, 2'd0, 0, "R7 busy low");
    // R8/R9: vector drain in ascending order
    legacy = 1;
    step(16'h001D, 0, 0, 2'd0, 0, "");
    for (int k = 0; k < 5; k++) step(0, 0, 1, 2'd2, 0, "R8 R9 vector drain");
    step(0, 0, 1, 2'd0, 0, "R9 vector cleared");
    // R4 with vector read
    step(16'h0004, 0, 0, 2'd0, 0, "");
    step(16'h0004, 0, 1, 2'd2, 0, "R8 vector code");
    step(0, 0, 1, 2'd0, 0, "R4 vector clear loses");
    // R10: non-legacy vector and address 3
    legacy = 0;
    step(0, 0, 1, 2'd2, 0, "R10 vector off");
    step(0, 0, 1, 2'd0, 0, "R10 no clear");
    step(0, 0, 1, 2'd3, 0, "R10 addr3");

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] e;
      int op;
      e = ($urandom % 3 == 0) ? 16'($urandom & $urandom) : 16'h0;
      if ($urandom % 50 == 0) legacy = ~legacy;
      if ($urandom % 7 == 0) bus_busy = ~bus_busy;
      op = $urandom % 6;
      case (op)
        0: step(e, 1, 0, 2'd0, 16'($urandom & $urandom), "R3 random");
        1: step(e, 1, 0, 2'd1, 16'($urandom), "R6 random");
        2, 3: step(e, 0, 1, 2'd2, 0, "R8 R9 random vector");
        4: step(e, 0, 1, 2'd0, 0, "R2 random status");
        default: step(e, 0, 1, 2'($urandom), 0, "R10 random read");
      endcase
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule